// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the digital slave side of a byte-wide serial EEPROM on an SPI bus in clock mode 0. It takes chip select, serial clock, data in, hold and write protect. It drives a serial data output together with an output enable, so that the pad is released whenever the enable is low. All pins are sampled in the core clock domain, and serial clock edges are found there. The core clock must therefore run several times faster than the serial clock.

A serial state machine decodes the opcode, collects a 16-bit address and then does one of several things. It streams array bytes or the status byte out. It fills a page buffer with write data, or it takes a new status byte. A second state machine runs the self-timed write cycle. That cycle starts when chip select rises. It copies the buffered bytes into an on-chip register array that stands in for the nonvolatile cells, then waits out a write-time counter. Block-protect bits in the status register make part of the array read-only. A status write-disable bit, together with the write-protect pin, freezes those protection bits.

Serial states: S_IDLE (deselected or waiting for a chip-select falling edge), S_OPC (shifting the opcode), S_ADDR (shifting 16 address bits), S_RDARR (array bytes out), S_RDSR (status bytes out), S_WRDAT (write data in), S_WRSR (status byte in), S_SKIP (command refused, wait for deselect). The serial transitions are as follows:
- S_IDLE goes to S_OPC on a chip-select fall.
- S_OPC goes to S_RDSR, S_ADDR, S_WRSR or S_SKIP on the eighth bit.
- S_ADDR goes to S_RDARR or S_WRDAT on the sixteenth bit.
- Every state goes to S_IDLE while chip select is high.

Write states: W_IDLE, W_PROG (one page slot per cycle) and W_WAIT (write time runs out). The write transitions are as follows:
- W_IDLE goes to W_PROG on an accepted array write.
- W_IDLE goes to W_WAIT on an accepted status write.
- W_PROG goes to W_WAIT after the last page slot.
- W_WAIT goes to W_IDLE when the timer ends.

Top module: `spi_ee_slave`

## Requirements
- R1: Opcode, address and write data bits are taken MSB first on serial clock rising edges. Read data leaves MSB first, one bit per falling edge. The first data bit is driven on the falling edge that follows the last opcode bit (status read) or the last address bit (array read), and the output enable is low before that edge.
- R2: While chip select is high, the output enable is low and the serial engine returns to S_IDLE. Any command in progress is abandoned.
- R3: After reset, nothing is decoded until chip select has fallen. Clock edges during a selection that began before reset ended have no effect.
- R4: With chip select low and hold low, the bit counters and the shift state are frozen, the output enable is low, and clock and data-in edges are ignored. Hold has no effect while chip select is high.
- R5: The opcodes are 0x06 (set write-enable latch), 0x04 (clear latch), 0x05 (read status), 0x01 (write status), 0x03 (read array) and 0x02 (write array). The status byte is: bit 0 write-in-progress, bit 1 latch, bits 3:2 protect field, bit 7 status write-disable, and the other bits read 0. Opcodes 0x06 and 0x04 act on their eighth bit.
- R6: An array read returns consecutive bytes from the low ARR_AW address bits. The address increments and wraps from the top of the array to 0 while chip select stays low. After reset, every byte reads 0xFF.
- R7: An array write is refused unless the latch is set. Data bytes land at consecutive offsets that wrap within the 2^PAGE_AW-byte page of the start address, and a later byte replaces an earlier one at the same offset.
- R8: A write cycle starts only when chip select rises after a whole number of data bytes, at least one of which is kept. An extra partial byte, or no data at all, writes nothing and leaves write-in-progress clear.
- R9: During a write cycle, write-in-progress reads 1 for at least WR_CYCLES core clocks. Only opcode 0x05 is accepted while it is set, and a refused read drives nothing. At the end of the cycle, both write-in-progress and the latch read 0.
- R10: The protect field 00, 01, 10 and 11 makes none, the top quarter, the top half or the whole of the array read-only. Data bytes aimed at a read-only byte are dropped, and the rest of the page still updates.
- R11: A status write needs the latch and one whole byte, and it updates bits 7, 3 and 2. It is ignored, with the latch kept, while write-protect is low and bit 7 is set.
- R12: A status read repeats the status byte, re-read live at each byte boundary, for as long as chip select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, several times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data into the block |
| hold_n | input | 1 | Pause of the serial engine, active low |
| wp_n | input | 1 | Write protect, active low |
| miso | output | 1 | Serial data out of the block, valid while miso_oe is high |
| miso_oe | output | 1 | Output enable; low means the output is high impedance |

## Verification
The whole array of a small configuration is filled page by page with an arithmetic pattern. It is then read back in one sequential stream that runs past the top. This separates address-increment, wrap-to-zero and bit-order faults from one another. All four protect settings are each tried against a probe byte in every quarter of the array, which tells a wrong protection threshold apart from a write that is lost altogether. Several short writes are also run: one that wraps within a page, one with a trailing partial byte, one with no data, and one with the latch clear. They separate the start rule of the write cycle from the offset wrap. Busy polling, a read refused while busy, a hold in the middle of a byte with stray clocks, and status writes under each combination of the write-protect pin and the write-disable bit round out the run.

// File: rtl/ee_pkg.sv
package ee_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef enum logic [2:0] {
        S_IDLE, S_OPC, S_ADDR, S_RDARR, S_RDSR, S_WRDAT, S_WRSR, S_SKIP
    } ser_st_t;

    typedef enum logic [1:0] {
        W_IDLE, W_PROG, W_WAIT
    } wr_st_t;

    // Read-only region test from the protect field and the two top address bits.
    function automatic logic zone_locked(input logic [1:0] bp, input logic [1:0] top);
        case (bp)
            2'b00:   zone_locked = 1'b0;
            2'b01:   zone_locked = (top == 2'b11);
            2'b10:   zone_locked = top[1];
            default: zone_locked = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/ee_array.sv
module ee_array #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata,
    input  logic [1:0]    bp
);
    import ee_pkg::*;

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R10: the programming pass never lands on a read-only byte
    p_no_locked_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !zone_locked(bp, waddr[AW-1:AW-2]));

endmodule

// File: rtl/ee_pagebuf.sv
module ee_pagebuf #(
    parameter int PAW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           we,
    input  logic [PAW-1:0] woff,
    input  logic [7:0]     wdata,
    input  logic [PAW-1:0] roff,
    output logic [7:0]     rdata,
    output logic           rvalid,
    output logic           any
);
    localparam int PB = 1 << PAW;

    logic [7:0]    dat [PB];
    logic [PB-1:0] vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   vld <= '0;
        else if (clr) vld <= '0;
        else if (we)  vld[woff] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (we) dat[woff] <= wdata;
    end

    assign rdata  = dat[roff];
    assign rvalid = vld[roff];
    assign any    = |vld;

endmodule

// File: rtl/ee_wtimer.sv
module ee_wtimer #(
    parameter int LEN = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic run
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (run) begin
            if (cnt == CW'(LEN - 1)) run <= 1'b0;
            else                     cnt <= cnt + 1'b1;
        end
    end

    // R9: a started write cycle is timed
    p_timer_runs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> run);

endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave #(
    parameter int ARR_AW    = 10,
    parameter int PAGE_AW   = 6,
    parameter int WR_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic hold_n,
    input  logic wp_n,
    output logic miso,
    output logic miso_oe
);
    import ee_pkg::*;

    localparam int PB    = 1 << PAGE_AW;
    localparam int T_LEN = (WR_CYCLES > PB) ? WR_CYCLES : PB + 1;
    localparam int SH_W  = (ARR_AW > 8) ? ARR_AW : 8;

    // pin sampling
    logic cs_d1, cs_d2, sck_d1, sck_d2, mosi_d1, hold_d1, wp_d1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d1 <= 1'b0;  cs_d2 <= 1'b0;
            sck_d1 <= 1'b0; sck_d2 <= 1'b0;
            mosi_d1 <= 1'b0; hold_d1 <= 1'b1; wp_d1 <= 1'b1;
        end else begin
            cs_d1 <= cs_n;  cs_d2 <= cs_d1;
            sck_d1 <= sck;  sck_d2 <= sck_d1;
            mosi_d1 <= mosi; hold_d1 <= hold_n; wp_d1 <= wp_n;
        end
    end

    logic cs_fall, cs_rise, hold_act, sck_rise, sck_fall;
    assign cs_fall  = cs_d2 & ~cs_d1;
    assign cs_rise  = ~cs_d2 & cs_d1;
    assign hold_act = ~hold_d1 & ~cs_d1;
    assign sck_rise = sck_d1 & ~sck_d2 & ~cs_d1 & ~hold_act;
    assign sck_fall = ~sck_d1 & sck_d2 & ~cs_d1 & ~hold_act;

    // serial engine registers
    ser_st_t             state, nxt;
    wr_st_t              wstate, wnxt;
    logic [SH_W-2:0]     in_sh;
    logic [3:0]          in_cnt;
    logic [2:0]          out_cnt;
    logic [7:0]          out_sh;
    logic                miso_r, started, load_req, rd_op, sr_got;
    logic [ARR_AW-1:0]   addr_q;
    logic [PAGE_AW-1:0]  off_q;
    logic [1:0]          sr_bp_n;
    logic                sr_wd_n;
    // status and write engine
    logic                wel, srwd, wip, t_run;
    logic [1:0]          bp;
    logic [PAGE_AW-1:0]  pidx;
    logic [ARR_AW-PAGE_AW-1:0] wbase;

    logic [SH_W-1:0]   in_word;
    logic [7:0]        in_byte, status, arr_rd, pb_rd;
    logic              byte_end, pb_we, pb_clr, pb_rv, pb_any;
    logic              start_arr, start_sr, arr_we;
    logic [ARR_AW-1:0] pb_tgt, arr_wa;

    assign in_word  = {in_sh, mosi_d1};
    assign in_byte  = in_word[7:0];
    assign byte_end = sck_rise && (in_cnt[2:0] == 3'd7);
    assign wip      = (wstate != W_IDLE);
    assign status   = {srwd, 3'b000, bp, wel, wip};

    // serial state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (cs_d1) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: if (cs_fall) nxt = S_OPC;
                S_OPC: if (byte_end) begin
                    if (in_byte == OP_RDSR)                 nxt = S_RDSR;
                    else if (wip)                           nxt = S_SKIP;
                    else if (in_byte == OP_READ)            nxt = S_ADDR;
                    else if (in_byte == OP_WRITE && wel)    nxt = S_ADDR;
                    else if (in_byte == OP_WRSR && wel)     nxt = S_WRSR;
                    else                                    nxt = S_SKIP;
                end
                S_ADDR: if (sck_rise && in_cnt == 4'd15) nxt = rd_op ? S_RDARR : S_WRDAT;
                S_RDARR, S_RDSR, S_WRDAT, S_WRSR, S_SKIP: ;
            endcase
        end
    end

    // serial datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_sh <= '0; in_cnt <= '0; out_cnt <= '0; out_sh <= '0;
            miso_r <= 1'b0; started <= 1'b0; load_req <= 1'b0; rd_op <= 1'b0;
            sr_got <= 1'b0; addr_q <= '0; off_q <= '0; sr_bp_n <= '0; sr_wd_n <= 1'b0;
        end else if (cs_fall) begin
            in_cnt <= '0; out_cnt <= '0; started <= 1'b0; sr_got <= 1'b0; load_req <= 1'b0;
        end else begin
            if (load_req) begin
                out_sh   <= (state == S_RDSR) ? status : arr_rd;
                load_req <= 1'b0;
            end
            if (sck_rise) begin
                in_sh  <= in_word[SH_W-2:0];
                in_cnt <= byte_end ? 4'd0 : in_cnt + 1'b1;
                unique case (state)
                    S_OPC: if (byte_end) begin
                        rd_op <= (in_byte == OP_READ);
                        if (in_byte == OP_RDSR) load_req <= 1'b1;
                    end
                    S_ADDR: begin
                        in_cnt <= in_cnt + 1'b1;
                        if (in_cnt == 4'd15) begin
                            addr_q   <= in_word[ARR_AW-1:0];
                            off_q    <= in_word[PAGE_AW-1:0];
                            load_req <= rd_op;
                        end
                    end
                    S_WRDAT: if (byte_end) off_q <= off_q + 1'b1;
                    S_WRSR: if (byte_end && !sr_got) begin
                        sr_bp_n <= in_byte[3:2];
                        sr_wd_n <= in_byte[7];
                        sr_got  <= 1'b1;
                    end
                    S_IDLE, S_RDARR, S_RDSR, S_SKIP: ;
                endcase
            end
            if (sck_fall && (state == S_RDARR || state == S_RDSR)) begin
                miso_r  <= out_sh[7];
                out_sh  <= {out_sh[6:0], 1'b0};
                out_cnt <= out_cnt + 1'b1;
                started <= 1'b1;
                if (out_cnt == 3'd7) begin
                    load_req <= 1'b1;
                    if (state == S_RDARR) addr_q <= addr_q + 1'b1;
                end
            end
        end
    end

    assign miso    = miso_r;
    assign miso_oe = (state == S_RDARR || state == S_RDSR) && started && !hold_act && !cs_d1;

    // page buffer fill
    assign pb_tgt = {addr_q[ARR_AW-1:PAGE_AW], off_q};
    assign pb_we  = byte_end && (state == S_WRDAT) && !zone_locked(bp, pb_tgt[ARR_AW-1:ARR_AW-2]);
    assign pb_clr = sck_rise && (state == S_ADDR) && (in_cnt == 4'd15) && !rd_op;

    // write-cycle start decisions
    assign start_arr = cs_rise && (state == S_WRDAT) && (in_cnt == 4'd0) && pb_any && !wip;
    assign start_sr  = cs_rise && (state == S_WRSR) && (in_cnt == 4'd0) && sr_got && !wip
                       && !(srwd && !wp_d1);

    // write state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wstate <= W_IDLE;
        else        wstate <= wnxt;
    end

    always_comb begin
        wnxt = wstate;
        unique case (wstate)
            W_IDLE: if (start_arr) wnxt = W_PROG; else if (start_sr) wnxt = W_WAIT;
            W_PROG: if (pidx == PAGE_AW'(PB - 1)) wnxt = W_WAIT;
            W_WAIT: if (!t_run) wnxt = W_IDLE;
            default: wnxt = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pidx <= '0; wbase <= '0;
        end else begin
            pidx <= (wstate == W_PROG) ? pidx + 1'b1 : '0;
            if (start_arr) wbase <= addr_q[ARR_AW-1:PAGE_AW];
        end
    end

    assign arr_we = (wstate == W_PROG) && pb_rv;
    assign arr_wa = {wbase, pidx};

    // status register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel <= 1'b0; bp <= 2'b00; srwd <= 1'b0;
        end else begin
            if (byte_end && state == S_OPC && !wip) begin
                if (in_byte == OP_WREN) wel <= 1'b1;
                if (in_byte == OP_WRDI) wel <= 1'b0;
            end
            if (start_sr) begin
                bp   <= sr_bp_n;
                srwd <= sr_wd_n;
            end
            if (wstate == W_WAIT && !t_run) wel <= 1'b0;
        end
    end

    ee_array #(.AW(ARR_AW)) i_array (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_wa), .wdata(pb_rd),
        .raddr(addr_q), .rdata(arr_rd), .bp(bp)
    );

    ee_pagebuf #(.PAW(PAGE_AW)) i_pagebuf (
        .clk(clk), .rst_n(rst_n), .clr(pb_clr), .we(pb_we), .woff(off_q), .wdata(in_byte),
        .roff(pidx), .rdata(pb_rd), .rvalid(pb_rv), .any(pb_any)
    );

    ee_wtimer #(.LEN(T_LEN)) i_wtimer (
        .clk(clk), .rst_n(rst_n), .start(start_arr | start_sr), .run(t_run)
    );

    // R2: a deselect always returns the engine to idle
    p_desel_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_d1 |=> state == S_IDLE);

    // R4: hold freezes the bit counters
    p_hold_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_act |=> $stable(in_cnt) && $stable(out_cnt));

    // R9: while busy, a decoded opcode can only lead to a status read or a refusal
    p_busy_rdsr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && state == S_OPC && byte_end) |=> (state == S_RDSR || state == S_SKIP || state == S_IDLE));

    // R8: a write cycle begins only on a chip-select rise
    p_start_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(cs_rise));

    // R9: the latch is clear when the cycle ends
    p_wel_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

    // R11: pin low plus write-disable bit freeze the protection bits
    p_srwd_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (srwd && !wp_d1) |=> $stable(bp) && $stable(srwd));

endmodule

// File: tb/test_spi_ee_slave.sv
`timescale 1ns/1ps
module test_spi_ee_slave;

    localparam int AW = 8;
    localparam int PAW = 4;
    localparam int WRC = 300;
    localparam int H = 4;
    localparam int NB = 1 << AW;
    localparam int PB = 1 << PAW;

    logic clk = 1'b0;
    logic rst_n, cs_n, sck, mosi, hold_n, wp_n, miso, miso_oe;

    always #2 clk = ~clk;

    spi_ee_slave #(.ARR_AW(AW), .PAGE_AW(PAW), .WR_CYCLES(WRC)) i_spi_ee_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .hold_n(hold_n), .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe)
    );

    int tests = 0, fails = 0;
    logic [7:0] em [NB];
    logic [7:0] wbuf [PB];
    logic [1:0] cur_bp = 2'b00;

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bitx(input logic b, output logic r, output logic oe);
        mosi = b;
        tick(H);
        r = miso; oe = miso_oe;
        sck = 1'b1;
        tick(H);
        sck = 1'b0;
    endtask

    task automatic bytex(input logic [7:0] tx, output logic [7:0] rx,
                         output logic oe_all, output logic oe_any);
        logic r, o;
        oe_all = 1'b1; oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bitx(tx[i], r, o);
            rx[i] = r; oe_all &= o; oe_any |= o;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0; tick(H);
    endtask

    task automatic desel();
        tick(H); cs_n = 1'b1; tick(2 * H);
    endtask

    task automatic op1(input logic [7:0] op);
        logic [7:0] rx; logic a, b;
        sel(); bytex(op, rx, a, b); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] rx; logic a, b;
        sel(); bytex(8'h05, rx, a, b); bytex(8'h00, s, a, b); desel();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] rx; logic a, b;
        sel(); bytex(8'h01, rx, a, b); bytex(v, rx, a, b); desel();
    endtask

    task automatic wait_done();
        tick(WRC + 40);
    endtask

    function automatic logic locked(input logic [1:0] bp, input int a);
        int nq;
        nq = (bp == 2'd0) ? 0 : (bp == 2'd1) ? 1 : (bp == 2'd2) ? 2 : 4;
        return (a / (NB / 4)) >= (4 - nq);
    endfunction

    // page write of n bytes from wbuf; model updated only if commit expected
    task automatic wr_mem(input int a, input int n, input logic wel_set);
        logic [7:0] rx; logic x, y;
        sel(); bytex(8'h02, rx, x, y); bytex(8'h00, rx, x, y); bytex(a[7:0], rx, x, y);
        for (int k = 0; k < n; k++) bytex(wbuf[k], rx, x, y);
        desel();
        if (wel_set)
            for (int k = 0; k < n; k++) begin
                int t;
                t = (a & ~(PB - 1)) | ((a + k) % PB);
                if (!locked(cur_bp, t)) em[t] = wbuf[k];
            end
    endtask

    task automatic rd_chk(input string tag, input int a, input int n);
        logic [7:0] rx; logic oa, on;
        sel(); bytex(8'h03, rx, oa, on);
        bytex(8'h00, rx, oa, on);
        bytex(a[7:0], rx, oa, on);
        chk({tag, " R1 oe low before data"}, on, 0);
        for (int i = 0; i < n; i++) begin
            bytex(8'h00, rx, oa, on);
            if (i == 0) chk({tag, " R1 oe with first data bit"}, oa, 1);
            chk($sformatf("%s R6 byte at %0h", tag, (a + i) % NB), rx, em[(a + i) % NB]);
        end
        desel();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] s, rx;
        logic oa, on, r, o;
        for (int i = 0; i < NB; i++) em[i] = 8'hFF;
        rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; mosi = 1'b0; hold_n = 1'b1; wp_n = 1'b1;
        tick(5);
        rst_n = 1'b1;
        tick(4);
        chk("R2 reset oe", miso_oe, 0);

        // R3: selection that began before reset released decodes nothing
        bytex(8'h05, rx, oa, on);
        bytex(8'h00, rx, oa, on);
        chk("R3 no decode without cs fall", on, 0);
        cs_n = 1'b1; tick(2 * H);
        chk("R2 oe low while deselected", miso_oe, 0);

        rdsr(s); chk("R5 status after reset", s, 8'h00);
        rd_chk("R6 erased", 8'h10, 2);

        op1(8'h06); rdsr(s); chk("R5 latch set", s, 8'h02);
        op1(8'h04); rdsr(s); chk("R5 latch cleared", s, 8'h00);

        // R7: write without latch refused
        wbuf[0] = 8'h5A;
        wr_mem(8'h05, 1, 1'b0);
        rdsr(s); chk("R7 no cycle without latch", s, 8'h00);
        wait_done();
        rd_chk("R7 refused write", 8'h05, 1);

        // fill every page; busy behaviour on the first
        for (int p = 0; p < NB / PB; p++) begin
            op1(8'h06);
            for (int k = 0; k < PB; k++) wbuf[k] = 8'((p * PB + k) * 37 + 11);
            wr_mem(p * PB, PB, 1'b1);
            if (p == 0) begin
                rdsr(s); chk("R9 busy status", s, 8'h03);
                sel(); bytex(8'h03, rx, oa, on); bytex(8'h00, rx, oa, on);
                bytex(8'h00, rx, oa, on); bytex(8'h00, rx, oa, on);
                chk("R9 read refused while busy", on, 0);
                desel();
            end
            wait_done();
            if (p == 0) begin
                rdsr(s); chk("R9 cycle end clears wip and latch", s, 8'h00);
            end
        end
        rd_chk("R6 sequential with wrap", 0, NB + 4);

        // R7: page wrap within page
        op1(8'h06);
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
        wr_mem(8'h2E, 3, 1'b1);
        wait_done();
        rd_chk("R7 page wrap", 8'h20, PB);

        // R8: trailing partial byte
        op1(8'h06);
        sel(); bytex(8'h02, rx, oa, on); bytex(8'h00, rx, oa, on); bytex(8'h40, rx, oa, on);
        bytex(8'h77, rx, oa, on);
        for (int i = 0; i < 3; i++) bitx(1'b1, r, o);
        desel();
        rdsr(s); chk("R8 partial byte no cycle", s, 8'h02);
        // R8: no data bytes
        sel(); bytex(8'h02, rx, oa, on); bytex(8'h00, rx, oa, on); bytex(8'h41, rx, oa, on);
        desel();
        rdsr(s); chk("R8 empty write no cycle", s, 8'h02);
        rd_chk("R8 partial discarded", 8'h40, 2);
        op1(8'h04);

        // R10 / R11: protect settings against every quarter
        for (int b = 0; b < 4; b++) begin
            op1(8'h06); wrsr(8'(b << 2)); wait_done();
            cur_bp = 2'(b);
            rdsr(s); chk($sformatf("R11 protect field %0d", b), s, b << 2);
            for (int q = 0; q < 4; q++) begin
                int a;
                a = q * (NB / 4) + 5;
                op1(8'h06);
                wbuf[0] = 8'(8'h80 + b * 4 + q);
                wr_mem(a, 1, 1'b1);
                wait_done();
                rd_chk($sformatf("R10 bp%0d q%0d", b, q), a, 1);
            end
        end
        op1(8'h06); wrsr(8'h00); wait_done(); cur_bp = 2'b00;
        op1(8'h04);

        // R11: write-disable with pin
        op1(8'h06); wrsr(8'h80); wait_done();
        rdsr(s); chk("R11 disable bit set", s, 8'h80);
        wp_n = 1'b0;
        op1(8'h06); wrsr(8'h0C); wait_done();
        rdsr(s); chk("R11 locked status write ignored", s, 8'h82);
        wp_n = 1'b1;
        wrsr(8'h00); wait_done();
        rdsr(s); chk("R11 unlocked status write", s, 8'h00);

        // R4: hold in mid byte with stray clocks
        sel(); bytex(8'h03, rx, oa, on); bytex(8'h00, rx, oa, on); bytex(8'h33, rx, oa, on);
        rx = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            if (i == 4) begin
                tick(H); hold_n = 1'b0; tick(H);
                chk("R4 oe low in hold", miso_oe, 0);
                for (int k = 0; k < 3; k++) begin
                    mosi = ~mosi; sck = 1'b1; tick(H); sck = 1'b0; tick(H);
                end
                hold_n = 1'b1;
            end
            bitx(1'b0, r, o);
            rx[i] = r;
        end
        chk("R4 byte across hold", rx, em[8'h33]);
        bytex(8'h00, rx, oa, on);
        chk("R4 next byte after hold", rx, em[8'h34]);
        desel();
        hold_n = 1'b0; tick(2 * H); hold_n = 1'b1;
        rd_chk("R4 hold while deselected", 8'h35, 1);

        // R12: live status polling
        op1(8'h06); wbuf[0] = 8'h3C; wr_mem(8'h70, 1, 1'b1);
        sel(); bytex(8'h05, rx, oa, on);
        bytex(8'h00, rx, oa, on); chk("R12 first poll busy", rx, 8'h03);
        for (int i = 0; i < 4; i++) bytex(8'h00, rx, oa, on);
        chk("R12 later poll idle", rx, 8'h00);
        desel();
        rd_chk("R12 polled write landed", 8'h70, 1);

        summary();
        $finish;
    end

endmodule